// File: doc/BRIEF.md
# Multi-Region Memory Protection Checker

This block checks every bus access that targets one fixed protected address window against eight programmable region descriptors. Several masters share the window. The low master IDs belong to processors and the higher IDs belong to non-processor masters such as DMA engines. Each descriptor holds an inclusive first and last address, a set of rights for each master, a process-ID tag and a valid bit. An access that hits the window is granted when at least one valid, matching region allows it. If none does, the block flags a violation.

Software sets up the block through a word-addressed write port. That port holds a global enable, a write-one-to-clear command for the error record, and four words for each region. The check itself is combinational from the request signals. It is registered, so the grant or error response appears exactly one cycle after the request. On the first violation the block keeps a record of the faulting address, master, access kind and privilege. That record is held until software clears it.

Register map, by word address: 0 holds the global enable (bit 0). A write to 1 with bit 0 set clears the error record. Region r starts at word 16+4r, and its four words are laid out as follows:
- +0: first address.
- +1: last address.
- +2: rights.
- +3: tag word, with the valid bit at bit 31 and the process ID at bits 7:0.

The rights word packs these fields, from the low bits up:
- 3 bits of user rights for processor 0, then 3 bits for processor 1.
- 2 bits of supervisor code for processor 0, then 2 bits for processor 1.
- 2 process-ID enable bits, one per processor.
- 2 read bits, one per non-processor master.
- 2 write bits, one per non-processor master.

Top module: `memprot_checker`

## Requirements
- R1: A region matches an address when first <= address <= last, so both the first and the last address are inside the region and the next address past the last one is not.
- R2: A processor's 3-bit user rights field grants read with value 4 (bit 2), write with value 2 (bit 1) and execute with value 1 (bit 0). Combined values such as 5 (read and execute) and 7 (all) grant the union.
- R3: A supervisor-mode access by a processor uses a 2-bit code. Code 0 allows read, write and execute. Code 1 allows read and execute. Code 2 allows read and write. Code 3 reuses that processor's user rights field.
- R4: Non-processor masters (IDs 2 and 3) have only a read bit and a write bit per region. Their execute accesses (kind 2) are never allowed.
- R5: When a region's process-ID enable bit for a processor is set, the region applies to that processor only if the access's process ID equals the region's process ID. When the bit is clear, the process ID is ignored.
- R6: A region whose valid bit is clear never matches.
- R7: While the global enable is clear, every access is granted.
- R8: When several valid regions match an access, the access is granted if any one of them allows it.
- R9: Accesses outside the protected window (default 0x40040000 to 0x4007FFFF inclusive) are granted without any check.
- R10: An access presented with acc_valid yields rsp_valid on the next cycle with exactly one of rsp_grant and rsp_err set. Inside the window, rsp_err is set when no matching region allows the access. Access kinds are encoded read=0, write=1, execute=2.
- R11: The first violation captures address, master, kind and privilege into the error record and sets err_valid. Later violations leave the record unchanged. Writing word 1 with bit 0 set clears the record, and writing bit 0 as zero has no effect.
- R12: After reset the global enable is clear, no region is valid, err_valid is low and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_mst | input | 2 | Requesting master ID (0,1 processors; 2,3 others) |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| acc_sup | input | 1 | Supervisor privilege |
| acc_pid | input | 8 | Current process ID of the requester |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_grant | output | 1 | Access granted |
| rsp_err | output | 1 | Access refused, error response |
| err_valid | output | 1 | Error record holds a violation |
| err_addr | output | 32 | Captured faulting address |
| err_mst | output | 2 | Captured master ID |
| err_kind | output | 2 | Captured access kind |
| err_sup | output | 1 | Captured privilege |

## Verification
On every cycle, the assertions check the following. The response always follows its request by one cycle and carries exactly one of grant or error. A disabled checker or an out-of-window address always gives a grant. An error record that is held stays bit-for-bit stable until it is cleared. What cannot be seen from single-cycle properties is the meaning of the rights encodings. That covers the inclusive region bounds, the supervisor codes, process-ID filtering, union across overlapping regions, the ignoring of invalid regions, and which violation ends up in the record. These are shown only by the bench's configured region set and its table of accesses with known outcomes.

// File: rtl/memprot_pkg.sv
package memprot_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int NREG    = 8;
    localparam int NCPU    = 2;
    localparam int NBUS    = 2;
    localparam int NMST    = NCPU + NBUS;
    localparam int MST_W   = $clog2(NMST);
    localparam int PID_W   = 8;
    localparam int CFG_AW  = 6;

    // register map (word addresses)
    localparam int REG_CTRL     = 0;
    localparam int REG_ERRCLR   = 1;
    localparam int REG_RGN_BASE = 16;
    localparam int RGN_WORDS    = 4;

    // rights word bit positions
    localparam int USR_LSB = 0;
    localparam int SUP_LSB = USR_LSB + 3 * NCPU;
    localparam int PEN_LSB = SUP_LSB + 2 * NCPU;
    localparam int BRD_LSB = PEN_LSB + NCPU;
    localparam int BWR_LSB = BRD_LSB + NBUS;
    localparam int VALID_BIT = 31;

    // supervisor codes
    localparam logic [1:0] SUP_RWX    = 2'd0;
    localparam logic [1:0] SUP_RX     = 2'd1;
    localparam logic [1:0] SUP_RW     = 2'd2;
    localparam logic [1:0] SUP_ASUSER = 2'd3;

    typedef enum logic [1:0] {
        ACC_RD = 2'd0,
        ACC_WR = 2'd1,
        ACC_EX = 2'd2,
        ACC_RSV = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic                     valid;
        logic [PID_W-1:0]         pid;
        logic [NBUS-1:0]          bus_wr;
        logic [NBUS-1:0]          bus_rd;
        logic [NCPU-1:0]          pid_en;
        logic [NCPU-1:0][1:0]     sup;
        logic [NCPU-1:0][2:0]     usr;
        logic [ADDR_W-1:0]        last;
        logic [ADDR_W-1:0]        first;
    } region_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [MST_W-1:0]  mst;
        acc_kind_e         kind;
        logic              sup;
        logic [PID_W-1:0]  pid;
    } access_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [MST_W-1:0]  mst;
        acc_kind_e         kind;
        logic              sup;
    } err_info_t;

    // rights in {r,w,x} order that apply for a processor access
    function automatic logic [2:0] eff_rights(logic [2:0] usr, logic [1:0] code, logic is_sup);
        logic [2:0] r;
        if (!is_sup) begin
            r = usr;
        end else begin
            case (code)
                SUP_RWX: r = 3'b111;
                SUP_RX:  r = 3'b101;
                SUP_RW:  r = 3'b110;
                default: r = usr;
            endcase
        end
        return r;
    endfunction

    function automatic logic rights_allow(logic [2:0] rwx, acc_kind_e kind);
        logic ok;
        case (kind)
            ACC_RD:  ok = rwx[2];
            ACC_WR:  ok = rwx[1];
            ACC_EX:  ok = rwx[0];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/memprot_regfile.sv
module memprot_regfile
    import memprot_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output region_t               rgn [NREG],
    output logic                  chk_en,
    output logic                  err_clr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_en <= 1'b0;
        end else if (cfg_we && cfg_addr == CFG_AW'(REG_CTRL)) begin
            chk_en <= cfg_wdata[0];
        end
    end

    assign err_clr = cfg_we && (cfg_addr == CFG_AW'(REG_ERRCLR)) && cfg_wdata[0];

    for (genvar r = 0; r < NREG; r++) begin : g_rgn
        localparam logic [CFG_AW-1:0] A_FIRST = CFG_AW'(REG_RGN_BASE + r * RGN_WORDS);
        localparam logic [CFG_AW-1:0] A_LAST  = CFG_AW'(REG_RGN_BASE + r * RGN_WORDS + 1);
        localparam logic [CFG_AW-1:0] A_PERM  = CFG_AW'(REG_RGN_BASE + r * RGN_WORDS + 2);
        localparam logic [CFG_AW-1:0] A_TAG   = CFG_AW'(REG_RGN_BASE + r * RGN_WORDS + 3);

        region_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == A_FIRST) q.first <= cfg_wdata[ADDR_W-1:0];
                if (cfg_addr == A_LAST)  q.last  <= cfg_wdata[ADDR_W-1:0];
                if (cfg_addr == A_PERM) begin
                    for (int k = 0; k < NCPU; k++) begin
                        q.usr[k]    <= cfg_wdata[USR_LSB + 3*k +: 3];
                        q.sup[k]    <= cfg_wdata[SUP_LSB + 2*k +: 2];
                        q.pid_en[k] <= cfg_wdata[PEN_LSB + k];
                    end
                    for (int j = 0; j < NBUS; j++) begin
                        q.bus_rd[j] <= cfg_wdata[BRD_LSB + j];
                        q.bus_wr[j] <= cfg_wdata[BWR_LSB + j];
                    end
                end
                if (cfg_addr == A_TAG) begin
                    q.valid <= cfg_wdata[VALID_BIT];
                    q.pid   <= cfg_wdata[PID_W-1:0];
                end
            end
        end

        assign rgn[r] = q;
    end

endmodule

// File: rtl/memprot_region_match.sv
module memprot_region_match
    import memprot_pkg::*;
(
    input  region_t rgn,
    input  access_t acc,
    output logic    hit,
    output logic    allow
);

    logic in_range;
    logic pid_ok;

    assign in_range = (acc.addr >= rgn.first) && (acc.addr <= rgn.last);

    always_comb begin
        pid_ok = 1'b1;
        for (int k = 0; k < NCPU; k++) begin
            if (acc.mst == MST_W'(k) && rgn.pid_en[k] && (acc.pid != rgn.pid)) begin
                pid_ok = 1'b0;
            end
        end
    end

    assign hit = rgn.valid && in_range && pid_ok;

    always_comb begin
        allow = 1'b0;
        for (int k = 0; k < NCPU; k++) begin
            if (acc.mst == MST_W'(k)) begin
                allow = rights_allow(eff_rights(rgn.usr[k], rgn.sup[k], acc.sup), acc.kind);
            end
        end
        for (int j = 0; j < NBUS; j++) begin
            if (acc.mst == MST_W'(NCPU + j)) begin
                case (acc.kind)
                    ACC_RD:  allow = rgn.bus_rd[j];
                    ACC_WR:  allow = rgn.bus_wr[j];
                    default: allow = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/memprot_errcap.sv
module memprot_errcap
    import memprot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      viol,
    input  err_info_t info_in,
    input  logic      clr,
    output logic      err_valid,
    output err_info_t info_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            info_q    <= '0;
        end else if (!err_valid || clr) begin
            err_valid <= viol;
            if (viol) info_q <= info_in;
        end
    end

    // R11
    hold_record_chk: assert property (@(posedge clk) disable iff (rst)
        (err_valid && !clr) |=> (err_valid && $stable(info_q)));

    // R11
    first_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (viol && !err_valid) |=> (err_valid && info_q == $past(info_in)));

endmodule

// File: rtl/memprot_checker.sv
module memprot_checker
    import memprot_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h4004_0000,
    parameter logic [31:0] WIN_LAST = 32'h4007_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic [1:0]  acc_mst,
    input  logic [1:0]  acc_kind,
    input  logic        acc_sup,
    input  logic [7:0]  acc_pid,
    output logic        rsp_valid,
    output logic        rsp_grant,
    output logic        rsp_err,
    output logic        err_valid,
    output logic [31:0] err_addr,
    output logic [1:0]  err_mst,
    output logic [1:0]  err_kind,
    output logic        err_sup
);

    region_t   rgn [NREG];
    logic      chk_en;
    logic      err_clr;
    access_t   acc;
    logic [NREG-1:0] hit;
    logic [NREG-1:0] allow;
    logic      in_win;
    logic      permit;
    logic      viol;
    err_info_t rec;

    memprot_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rgn       (rgn),
        .chk_en    (chk_en),
        .err_clr   (err_clr)
    );

    assign acc.addr = acc_addr;
    assign acc.mst  = acc_mst;
    assign acc.kind = acc_kind_e'(acc_kind);
    assign acc.sup  = acc_sup;
    assign acc.pid  = acc_pid;

    for (genvar r = 0; r < NREG; r++) begin : g_match
        memprot_region_match u_match (
            .rgn   (rgn[r]),
            .acc   (acc),
            .hit   (hit[r]),
            .allow (allow[r])
        );
    end

    assign in_win = (acc_addr >= WIN_BASE) && (acc_addr <= WIN_LAST);
    assign permit = !chk_en || !in_win || |(hit & allow);
    assign viol   = acc_valid && !permit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_grant <= acc_valid && permit;
            rsp_err   <= viol;
        end
    end

    memprot_errcap u_errcap (
        .clk       (clk),
        .rst       (rst),
        .viol      (viol),
        .info_in   ('{addr: acc_addr, mst: acc_mst, kind: acc_kind_e'(acc_kind), sup: acc_sup}),
        .clr       (err_clr),
        .err_valid (err_valid),
        .info_q    (rec)
    );

    assign err_addr = rec.addr;
    assign err_mst  = rec.mst;
    assign err_kind = rec.kind;
    assign err_sup  = rec.sup;

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    // R10
    no_rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_grant ^ rsp_err));

    // R7
    disabled_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !chk_en) |=> rsp_grant);

    // R9
    outside_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_addr < WIN_BASE || acc_addr > WIN_LAST)) |=> rsp_grant);

endmodule

// File: tb/memprot_checker_tb.sv
module memprot_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [1:0]  acc_mst;
    logic [1:0]  acc_kind;
    logic        acc_sup;
    logic [7:0]  acc_pid;
    logic        rsp_valid, rsp_grant, rsp_err;
    logic        err_valid;
    logic [31:0] err_addr;
    logic [1:0]  err_mst, err_kind;
    logic        err_sup;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    memprot_checker dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_mst(acc_mst),
        .acc_kind(acc_kind), .acc_sup(acc_sup), .acc_pid(acc_pid),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err(rsp_err),
        .err_valid(err_valid), .err_addr(err_addr), .err_mst(err_mst),
        .err_kind(err_kind), .err_sup(err_sup)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  mst;
        logic [1:0]  kind;
        logic        sup;
        logic [7:0]  pid;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VEC [NVEC] = '{
        '{32'h4004_0000, 2'd0, 2'd0, 1'b0, 8'h00, 1'b1, 4'd1},  // R1 first address
        '{32'h4004_FFFF, 2'd0, 2'd0, 1'b0, 8'h00, 1'b1, 4'd1},  // R1 last address
        '{32'h4005_0000, 2'd0, 2'd1, 1'b0, 8'h00, 1'b0, 4'd1},  // R1 past last: region1 RX only
        '{32'h4004_0010, 2'd0, 2'd1, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 read-only, write refused
        '{32'h4004_0010, 2'd0, 2'd2, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 execute refused
        '{32'h4004_0010, 2'd0, 2'd1, 1'b1, 8'h00, 1'b0, 4'd3},  // R3 code 3 as user
        '{32'h4005_0010, 2'd0, 2'd1, 1'b1, 8'h00, 1'b1, 4'd3},  // R3 code 2 RW
        '{32'h4005_0010, 2'd0, 2'd2, 1'b1, 8'h00, 1'b0, 4'd3},  // R3 code 2 no exec
        '{32'h4005_0010, 2'd0, 2'd2, 1'b0, 8'h99, 1'b1, 4'd2},  // R2 value 5 exec, R5 pid ignored
        '{32'h4004_0020, 2'd1, 2'd2, 1'b1, 8'h00, 1'b1, 4'd3},  // R3 code 0 RWX
        '{32'h4005_0020, 2'd1, 2'd1, 1'b0, 8'h21, 1'b1, 4'd5},  // R5 pid match
        '{32'h4005_0020, 2'd1, 2'd1, 1'b0, 8'h22, 1'b0, 4'd5},  // R5 pid mismatch
        '{32'h4004_8100, 2'd0, 2'd1, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 write from region2
        '{32'h4004_8100, 2'd0, 2'd0, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 read from region0
        '{32'h4004_8100, 2'd1, 2'd1, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 cpu1 via region0
        '{32'h4004_0040, 2'd2, 2'd0, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 bus0 read
        '{32'h4004_0040, 2'd2, 2'd1, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 bus0 write refused
        '{32'h4004_0040, 2'd3, 2'd0, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 bus1 read refused
        '{32'h4005_0040, 2'd2, 2'd1, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 bus0 write region1
        '{32'h4005_0040, 2'd2, 2'd2, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 bus exec refused
        '{32'h4006_0000, 2'd0, 2'd0, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 invalid region
        '{32'h4000_0000, 2'd0, 2'd1, 1'b0, 8'h00, 1'b1, 4'd9},  // R9 below window
        '{32'h4008_0000, 2'd0, 2'd1, 1'b0, 8'h00, 1'b1, 4'd9},  // R9 above window
        '{32'h4007_FFFF, 2'd0, 2'd1, 1'b0, 8'h00, 1'b0, 4'd10}  // R10 no region
    };

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(logic [31:0] a, logic [1:0] m, logic [1:0] k, logic s, logic [7:0] p);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_mst = m; acc_kind = k; acc_sup = s; acc_pid = p;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        acc_valid = 0; acc_addr = 0; acc_mst = 0; acc_kind = 0; acc_sup = 0; acc_pid = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check("R12 rsp_valid", rsp_valid, 0);
        check("R12 err_valid", err_valid, 0);
        // R12 enable clear after reset: in-window access with no region granted
        access(32'h4007_0000, 2'd0, 2'd1, 1'b0, 8'h00);
        check("R12 grant after reset", {rsp_valid, rsp_grant, rsp_err}, 3'b110);
        check("R12 no record", err_valid, 0);

        // region0 0x40040000..0x4004FFFF
        cfg_write(6'd16, 32'h4004_0000); cfg_write(6'd17, 32'h4004_FFFF);
        cfg_write(6'd18, 32'h0000_10FC); cfg_write(6'd19, 32'h8000_0000);
        // region1 0x40050000..0x4005FFFF, pid 0x21 for cpu1
        cfg_write(6'd20, 32'h4005_0000); cfg_write(6'd21, 32'h4005_FFFF);
        cfg_write(6'd22, 32'h0000_4BB5); cfg_write(6'd23, 32'h8000_0021);
        // region2 0x40048000..0x40048FFF, cpu0 write only
        cfg_write(6'd24, 32'h4004_8000); cfg_write(6'd25, 32'h4004_8FFF);
        cfg_write(6'd26, 32'h0000_03C2); cfg_write(6'd27, 32'h8000_0000);
        // region3 0x40060000..0x4006FFFF, all rights but invalid
        cfg_write(6'd28, 32'h4006_0000); cfg_write(6'd29, 32'h4006_FFFF);
        cfg_write(6'd30, 32'h0000_03C7); cfg_write(6'd31, 32'h0000_0000);
        cfg_write(6'd0, 32'h1);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i].addr, VEC[i].mst, VEC[i].kind, VEC[i].sup, VEC[i].pid);
            check($sformatf("R%0d vector %0d", VEC[i].req, i),
                  {rsp_valid, rsp_grant, rsp_err}, {1'b1, VEC[i].exp, !VEC[i].exp});
        end

        // R10 idle cycle gives no response
        @(negedge clk);
        check("R10 idle", rsp_valid, 0);

        // R11 record holds the first violation (vector 2)
        check("R11 valid", err_valid, 1);
        check("R11 addr", err_addr, 32'h4005_0000);
        check("R11 mst/kind/sup", {err_mst, err_kind, err_sup}, {2'd0, 2'd1, 1'b0});
        // R11 writing zero does not clear
        cfg_write(6'd1, 32'h0);
        check("R11 zero write ignored", {err_valid, err_addr}, {1'b1, 32'h4005_0000});
        cfg_write(6'd1, 32'h1);
        check("R11 cleared", err_valid, 0);
        access(32'h4007_FFF0, 2'd1, 2'd0, 1'b1, 8'h05);
        check("R11 new capture", {err_valid, err_addr, err_mst, err_kind, err_sup},
              {1'b1, 32'h4007_FFF0, 2'd1, 2'd0, 1'b1});

        // R6 validating region3 makes it apply
        cfg_write(6'd31, 32'h8000_0000);
        access(32'h4006_0000, 2'd0, 2'd0, 1'b0, 8'h00);
        check("R6 now valid", rsp_grant, 1);

        // R7 global enable cleared: refused access now granted, record unchanged
        cfg_write(6'd0, 32'h0);
        access(32'h4007_FFFF, 2'd3, 2'd2, 1'b0, 8'h00);
        check("R7 disabled grant", {rsp_valid, rsp_grant, rsp_err}, 3'b110);
        check("R7 record kept", {err_valid, err_addr}, {1'b1, 32'h4007_FFF0});

        done = 1;
        summary();
        $finish;
    end

endmodule